// File: doc/BRIEF.md
# Word-Controlled SPI Master

This block is an SPI master that pulls 22-bit transmit entries from a small internal queue. Each entry holds the data word and the control for that word. The control says which of four slave-select lines to drive during the word. It says whether the select lines drop once the word is done, and whether an idle gap separates this word from the next one. All framing decisions are therefore made word by word. Software builds a frame longer than 16 bits by queuing several words in a row, with the select held and no gap between them.

The block shifts data out in SPI mode 0 with the most significant bit of the active length first. It samples the slave's reply on each rising clock edge and presents the received word with a one-cycle valid strobe. A clock divider sets the serial clock rate. Two small counts, both in serial-clock periods, set the idle time after a transfer ends and after a frame ends. A configuration mask sets the electrical polarity of each select line separately.

Top module: `spi_word_master`

## Requirements
- R1: An entry is laid out as data in bits 15:0, four active-low select controls in bits 19:16 (bit 16+i low asserts line i), end-of-transfer in bit 20 and end-of-frame in bit 21. After reset every select pin is inactive, `sck` is 0, `rx_valid` is 0 and `wr_ready` is 1.
- R2: A word has `cfg_len`+1 bits. Bit `cfg_len` of the data goes out first and bit 0 goes out last. Data bits above the active length are not sent.
- R3: `sck` idles low. `mosi` changes only while `sck` is low. `miso` is sampled on the rising edge. Each half period of `sck` lasts `cfg_div`+1 clock cycles.
- R4: `rx_valid` is a one-cycle pulse in the cycle in which the last falling `sck` edge of a word appears. The received bits are then right-aligned in `rx_data`, with zeros above the active length.
- R5: A select line is driven active high when its `cfg_ss_pol` bit is 1 and active low when that bit is 0.
- R6: With end-of-transfer set, the select lines go inactive after the word. They stay inactive for at least `cfg_xfer_dly` `sck` periods before another word may assert them.
- R7: With end-of-transfer clear, the select lines stay asserted after the word, so the next word continues the same transfer.
- R8: With end-of-frame set, `sck` stays idle for at least `cfg_frame_dly` extra `sck` periods before the next word. With `cfg_frame_dly` = 0 the flag changes nothing in the timing.
- R9: When the queue is empty after a word whose end-of-transfer is clear, `sck` stays idle and the select lines stay asserted until a new entry arrives.
- R10: Entries are sent in the order they were written. `wr_ready` is low while the queue is full, and a write is accepted only when `wr_valid` and `wr_ready` are both high.
- R11: The select pins do not change while `sck` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Transmit entry offered |
| wr_entry | input | 22 | Transmit entry: data, select controls, end flags |
| wr_ready | output | 1 | Queue can accept an entry |
| cfg_len | input | 4 | Word length minus one |
| cfg_div | input | 8 | Half period of `sck` minus one, in clock cycles |
| cfg_ss_pol | input | 4 | Per-line select polarity, 1 = active high |
| cfg_xfer_dly | input | 4 | Idle `sck` periods after end of transfer |
| cfg_frame_dly | input | 4 | Idle `sck` periods after end of frame |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to slave |
| miso | input | 1 | Serial data from slave |
| ss_pin | output | 4 | Slave-select pins |
| rx_valid | output | 1 | Received word strobe |
| rx_data | output | 16 | Received word, right-aligned |

## Verification
When the queue holds an entry and the engine is idle, the entry is loaded on the next edge. The first rising `sck` edge follows `cfg_div`+1 cycles later, and `rx_valid` appears in the same cycle as the last falling `sck` edge. After that edge an end-of-transfer gap keeps the selects inactive for 2·`cfg_xfer_dly`·(`cfg_div`+1) cycles, plus the one cycle needed to load the next entry. The bench samples every output on the falling clock edge. Its scoreboard compares each word at the moment `rx_valid` is seen. Gaps are checked as cycle counts against a window of one cycle on either side of the computed value, so a late or missing gap shows up while loading latency does not.

// File: rtl/spi_wm_pkg.sv
// Shared widths, entry layout and sequencer states for the word-controlled SPI master.
// Assumes a 16-bit data field and four select lines; entry bit positions are fixed.
package spi_wm_pkg;
    localparam int DATA_W  = 16;
    localparam int NSS     = 4;
    localparam int LEN_W   = $clog2(DATA_W);
    localparam int ENTRY_W = DATA_W + NSS + 2;

    typedef struct packed {
        logic              frame_end;
        logic              xfer_end;
        logic [NSS-1:0]    sel_n;
        logic [DATA_W-1:0] data;
    } tx_entry_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2,
        ST_GAP  = 2'd3
    } seq_state_t;
endpackage

// File: rtl/spi_wm_fifo.sv
// Small synchronous FIFO holding transmit entries.
// Assumes DEPTH is a power of two; pop is only raised when not empty.
module spi_wm_fifo #(
    parameter int W     = 22,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [AW:0]   count;

    assign empty = (count == '0);
    assign full  = (count == (AW+1)'(DEPTH));
    assign head  = mem[rptr];

    // Storage write port.
    always_ff @(posedge clk) begin
        if (push && !full) begin
            mem[wptr] <= push_data;
        end
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push && !full) begin
                wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
            end
            if (pop && !empty) begin
                rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
            end
            case ({push && !full, pop && !empty})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/spi_wm_tick.sv
// Half-period tick generator for the serial clock.
// Counts clock cycles while enabled and pulses tick every div+1 cycles; clears when disabled.
module spi_wm_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = en && (cnt == div);

    // Cycle counter restarting on every tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/spi_wm_shift.sv
// Shift engine: aligns the active word so its top bit leaves first, shifts on falling
// edges and collects the sampled input on rising edges. Assumes load, rise and fall are exclusive.
module spi_wm_shift
    import spi_wm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic [LEN_W-1:0]  len,
    input  logic              rise,
    input  logic              fall,
    input  logic              miso,
    output logic              mosi,
    output logic              last,
    output logic [DATA_W-1:0] rx_word
);
    logic [DATA_W-1:0] tx_sr;
    logic [DATA_W-1:0] rx_sr;
    logic [LEN_W-1:0]  bits_left;

    assign mosi    = tx_sr[DATA_W-1];
    assign last    = (bits_left == '0);
    assign rx_word = rx_sr;

    // Transmit register and remaining-bit count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr     <= '0;
            bits_left <= '0;
        end else if (load) begin
            tx_sr     <= load_data << (LEN_W'(DATA_W-1) - len);
            bits_left <= len;
        end else if (fall && !last) begin
            tx_sr     <= tx_sr << 1;
            bits_left <= bits_left - 1'b1;
        end
    end

    // Receive register filled from the low end.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            rx_sr <= '0;
        end else if (rise) begin
            rx_sr <= {rx_sr[DATA_W-2:0], miso};
        end
    end
endmodule

// File: rtl/spi_wm_seq.sv
// Word sequencer: loads entries, generates sck edges from ticks, applies the select
// controls and runs the end-of-transfer and end-of-frame gaps (two ticks per sck period).
module spi_wm_seq
    import spi_wm_pkg::*;
#(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_empty,
    input  tx_entry_t        head,
    input  logic             tick,
    input  logic             last,
    input  logic [DLY_W-1:0] cfg_xfer_dly,
    input  logic [DLY_W-1:0] cfg_frame_dly,
    output logic             pop,
    output logic             load,
    output logic             rise,
    output logic             fall,
    output logic             busy,
    output logic             sck,
    output logic [NSS-1:0]   sel_act,
    output logic             rx_valid
);
    seq_state_t       state;
    logic             xfer_end_q, frame_end_q;
    logic [DLY_W:0]   gap_sum;
    logic [DLY_W+1:0] gap_left;

    assign busy    = (state != ST_IDLE);
    assign gap_sum = (xfer_end_q  ? {1'b0, cfg_xfer_dly}  : '0)
                   + (frame_end_q ? {1'b0, cfg_frame_dly} : '0);

    // Edge strobes decoded from state and tick.
    always_comb begin
        pop  = 1'b0;
        load = 1'b0;
        rise = 1'b0;
        fall = 1'b0;
        case (state)
            ST_IDLE: begin
                pop  = !fifo_empty;
                load = !fifo_empty;
            end
            ST_LOW:  rise = tick;
            ST_HIGH: fall = tick;
            default: ;
        endcase
    end

    // State, clock level, selects and gap countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            sck         <= 1'b0;
            sel_act     <= '0;
            xfer_end_q  <= 1'b0;
            frame_end_q <= 1'b0;
            gap_left    <= '0;
            rx_valid    <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (load) begin
                        sel_act     <= ~head.sel_n;
                        xfer_end_q  <= head.xfer_end;
                        frame_end_q <= head.frame_end;
                        state       <= ST_LOW;
                    end
                end
                ST_LOW: begin
                    if (tick) begin
                        sck   <= 1'b1;
                        state <= ST_HIGH;
                    end
                end
                ST_HIGH: begin
                    if (tick) begin
                        sck <= 1'b0;
                        if (last) begin
                            rx_valid <= 1'b1;
                            if (xfer_end_q) begin
                                sel_act <= '0;
                            end
                            if (gap_sum != '0) begin
                                gap_left <= {gap_sum, 1'b0};
                                state    <= ST_GAP;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else begin
                            state <= ST_LOW;
                        end
                    end
                end
                default: begin
                    if (tick) begin
                        gap_left <= gap_left - 1'b1;
                        if (gap_left == (DLY_W+2)'(1)) begin
                            state <= ST_IDLE;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/spi_word_master.sv
// Top level of the word-controlled SPI master (mode 0).
// Assumes configuration inputs are held stable while words are in flight.
module spi_word_master
    import spi_wm_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int DIV_W      = 8,
    parameter int DLY_W      = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_valid,
    input  logic [ENTRY_W-1:0] wr_entry,
    output logic               wr_ready,
    input  logic [LEN_W-1:0]   cfg_len,
    input  logic [DIV_W-1:0]   cfg_div,
    input  logic [NSS-1:0]     cfg_ss_pol,
    input  logic [DLY_W-1:0]   cfg_xfer_dly,
    input  logic [DLY_W-1:0]   cfg_frame_dly,
    output logic               sck,
    output logic               mosi,
    input  logic               miso,
    output logic [NSS-1:0]     ss_pin,
    output logic               rx_valid,
    output logic [DATA_W-1:0]  rx_data
);
    logic [ENTRY_W-1:0] head_bits;
    tx_entry_t          head;
    logic               fifo_empty, fifo_full;
    logic               pop, load, rise, fall, busy, tick, last;
    logic [NSS-1:0]     sel_act;

    assign head     = tx_entry_t'(head_bits);
    assign wr_ready = !fifo_full;

    // Map each logical select onto its pin polarity.
    for (genvar i = 0; i < NSS; i++) begin : g_sel_pin
        assign ss_pin[i] = cfg_ss_pol[i] ? sel_act[i] : ~sel_act[i];
    end

    spi_wm_fifo #(.W(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_valid),
        .push_data (wr_entry),
        .pop       (pop),
        .head      (head_bits),
        .empty     (fifo_empty),
        .full      (fifo_full)
    );

    spi_wm_tick #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (busy),
        .div   (cfg_div),
        .tick  (tick)
    );

    spi_wm_seq #(.DLY_W(DLY_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .fifo_empty    (fifo_empty),
        .head          (head),
        .tick          (tick),
        .last          (last),
        .cfg_xfer_dly  (cfg_xfer_dly),
        .cfg_frame_dly (cfg_frame_dly),
        .pop           (pop),
        .load          (load),
        .rise          (rise),
        .fall          (fall),
        .busy          (busy),
        .sck           (sck),
        .sel_act       (sel_act),
        .rx_valid      (rx_valid)
    );

    spi_wm_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_data (head.data),
        .len       (cfg_len),
        .rise      (rise),
        .fall      (fall),
        .miso      (miso),
        .mosi      (mosi),
        .last      (last),
        .rx_word   (rx_data)
    );
endmodule

// File: rtl/spi_wm_chk.sv
// Protocol checker for the word-controlled SPI master, attached by bind.
// Assumes configuration inputs are stable while words are in flight.
module spi_wm_chk #(
    parameter int NSS = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           sck,
    input logic           mosi,
    input logic [NSS-1:0] ss_pin,
    input logic           rx_valid
);
    AST_MOSI_MOVES_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mosi) |-> !sck); // R3
    AST_SEL_HOLD_SCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> $stable(ss_pin)); // R11
    AST_RX_WITH_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $fell(sck)); // R4
    AST_RX_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R4
endmodule

bind spi_word_master spi_wm_chk #(.NSS(spi_wm_pkg::NSS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck      (sck),
    .mosi     (mosi),
    .ss_pin   (ss_pin),
    .rx_valid (rx_valid)
);

// File: tb/spi_word_master_tb.sv
`timescale 1ns/1ps
module spi_word_master_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [21:0] wr_entry = '0;
    logic        wr_ready;
    logic [3:0]  cfg_len = 4'd15;
    logic [7:0]  cfg_div = 8'd1;
    logic [3:0]  cfg_ss_pol = 4'd0;
    logic [3:0]  cfg_xfer_dly = 4'd0;
    logic [3:0]  cfg_frame_dly = 4'd0;
    logic        sck, mosi, miso, rx_valid;
    logic [3:0]  ss_pin;
    logic [15:0] rx_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct {
        logic [15:0] tx;
        logic [15:0] rx;
        logic [3:0]  pins;
        int          nbits;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    assign miso = ~mosi;

    spi_word_master u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_entry(wr_entry),
        .wr_ready(wr_ready), .cfg_len(cfg_len), .cfg_div(cfg_div),
        .cfg_ss_pol(cfg_ss_pol), .cfg_xfer_dly(cfg_xfer_dly),
        .cfg_frame_dly(cfg_frame_dly), .sck(sck), .mosi(mosi), .miso(miso),
        .ss_pin(ss_pin), .rx_valid(rx_valid), .rx_data(rx_data)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_range(input string req, input string what, input int act,
                               input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
        end
    endtask

    // Driver: queue the expected word, then offer the entry until accepted.
    task automatic send(input logic [15:0] d, input logic [3:0] sel_n,
                        input bit xend, input bit fend);
        exp_t e;
        logic [15:0] mask;
        mask = 16'((32'h1 << (int'(cfg_len) + 1)) - 1);
        e.tx = d & mask;
        e.rx = ~d & mask;
        e.nbits = int'(cfg_len) + 1;
        for (int i = 0; i < 4; i++) e.pins[i] = cfg_ss_pol[i] ? ~sel_n[i] : sel_n[i];
        exp_q.push_back(e);
        @(negedge clk);
        while (!wr_ready) @(negedge clk);
        wr_valid = 1'b1;
        wr_entry = {fend, xend, sel_n, d};
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (80) @(negedge clk);
    endtask

    // Monitor: slave-side collection of mosi and scoreboard compare at rx_valid.
    logic [15:0] mon_bits = '0;
    int          mon_n = 0;
    int          hi_cnt = 0;
    logic        prev_sck = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (sck) hi_cnt++;
            if (sck && !prev_sck) begin
                mon_bits = {mon_bits[14:0], mosi};
                mon_n++;
                if (exp_q.size() != 0) check("R5", "select pins during word", ss_pin, exp_q[0].pins);
            end
            if (!sck && prev_sck) begin
                check("R3", "sck high cycles", hi_cnt, int'(cfg_div) + 1);
                hi_cnt = 0;
            end
            if (rx_valid) begin
                if (exp_q.size() == 0) begin
                    check("R10", "unexpected word", 1, 0);
                end else begin
                    exp_t e;
                    logic [15:0] mask;
                    e = exp_q.pop_front();
                    mask = 16'((32'h1 << e.nbits) - 1);
                    check("R4", "rx_data", rx_data, e.rx);
                    check("R2", "mosi word", mon_bits & mask, e.tx);
                    check("R2", "bit count", mon_n, e.nbits);
                end
                mon_bits = '0;
                mon_n = 0;
            end
            prev_sck = sck;
        end
    end

    // Watchdog.
    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    int gap;
    int gap_plain;
    bit saw_full;
    bit held;

    initial begin
        repeat (5) @(negedge clk);
        check("R1", "reset select pins", ss_pin, 4'hF);
        check("R1", "reset sck", sck, 0);
        check("R1", "reset rx_valid", rx_valid, 0);
        check("R10", "reset wr_ready", wr_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R4: full-length words on different lines.
        send(16'hA53C, 4'b1110, 1, 0);
        send(16'h0F81, 4'b1101, 1, 0);
        drain();

        // R2: shorter lengths, including single bit.
        cfg_len = 4'd7;
        send(16'h12C5, 4'b1011, 1, 0);
        drain();
        cfg_len = 4'd0;
        send(16'hFFFF, 4'b0111, 1, 0);
        send(16'hFFFE, 4'b0111, 1, 0);
        drain();

        // R10: back-to-back burst fills the queue, order kept.
        cfg_len = 4'd3;
        cfg_div = 8'd0;
        saw_full = 0;
        fork
            begin
                for (int k = 0; k < 8; k++) send(16'(k * 3 + 5), 4'b1110, 0, 0);
                send(16'h9, 4'b1110, 1, 0);
            end
            begin
                repeat (40) begin
                    @(negedge clk);
                    if (!wr_ready) saw_full = 1;
                end
            end
        join
        check("R10", "wr_ready dropped when full", saw_full, 1);
        drain();

        // R5: polarity mask.
        cfg_div = 8'd1;
        cfg_ss_pol = 4'b0101;
        send(16'h3, 4'b1010, 1, 0);
        drain();
        check("R5", "idle pins with mask", ss_pin, 4'b1010);
        cfg_ss_pol = 4'b0000;

        // R6: transfer gap of 3 periods at 4 cycles per period.
        cfg_xfer_dly = 4'd3;
        send(16'h5, 4'b1110, 1, 0);
        send(16'hA, 4'b1110, 1, 0);
        while (!rx_valid) @(negedge clk);
        gap = 0;
        while (ss_pin[0] == 1'b1) begin gap++; @(negedge clk); end
        check_range("R6", "select inactive cycles", gap, 12, 14);
        drain();
        cfg_xfer_dly = 4'd0;

        // R7 R8: frame gap of 2 periods with select held.
        cfg_frame_dly = 4'd2;
        send(16'h6, 4'b1110, 0, 1);
        send(16'h9, 4'b1110, 1, 0);
        while (!rx_valid) @(negedge clk);
        gap = 0;
        held = 1;
        while (sck == 1'b0) begin
            if (ss_pin[0] != 1'b0) held = 0;
            gap++;
            @(negedge clk);
        end
        check("R7", "select held across words", held, 1);
        check_range("R8", "sck idle with frame gap", gap, 10, 12);
        drain();

        // R8: frame delay of zero matches a plain continuation.
        cfg_frame_dly = 4'd0;
        send(16'h6, 4'b1110, 0, 0);
        send(16'h9, 4'b1110, 1, 0);
        while (!rx_valid) @(negedge clk);
        gap_plain = 0;
        while (sck == 1'b0) begin gap_plain++; @(negedge clk); end
        drain();
        send(16'h6, 4'b1110, 0, 1);
        send(16'h9, 4'b1110, 1, 0);
        while (!rx_valid) @(negedge clk);
        gap = 0;
        while (sck == 1'b0) begin gap++; @(negedge clk); end
        check("R8", "zero frame delay gap", gap, gap_plain);
        drain();

        // R9: stall with empty queue keeps select asserted and sck idle.
        send(16'hC, 4'b1110, 0, 0);
        while (!rx_valid) @(negedge clk);
        held = 1;
        repeat (40) begin
            @(negedge clk);
            if (sck != 1'b0 || ss_pin[0] != 1'b0) held = 0;
        end
        check("R9", "stall holds select, sck idle", held, 1);
        send(16'h3, 4'b1110, 1, 0);
        drain();
        check("R6", "select released at end", ss_pin, 4'hF);
        check("R10", "all words consumed", exp_q.size(), 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule